// File: doc/BRIEF.md
# Zero-Suppressed Serial Cell Readout

This block drains the stored results of a column of detector cells through a single serial line. Each cell offers a data word and a hit flag on a parallel bus. A start strobe copies every word, every flag and the compression setting into the block in one cycle. After that the bits leave one per clock. The shift clock is nominally 40 MHz.

Every cell gets a slot in the stream, and the slot length varies. The slot always begins with the cell's flag bit. With compression on, a cell that saw no hit ends its slot after that one bit. A hit cell, or any cell when compression is off, follows the flag with its whole data word. At occupancies of a few percent the stream is then not much longer than one bit per cell. A valid line marks the cycles that carry stream bits. A one-cycle done pulse closes the readout.

Top module: `zs_serial_readout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sdo`, `sdo_valid` and `done` are all 0.
- R2: A start strobe seen while idle captures `cell_data`, `cell_hit` and `compress_en` on that edge. Changes to those inputs during the readout do not change the stream that is sent.
- R3: The first stream bit appears in the cycle that follows the start edge. `sdo_valid` then stays 1, with no gaps, until the last bit of the last cell.
- R4: Each cell's slot opens with its flag bit: 1 for a hit cell, 0 for a cell without a hit.
- R5: With compression on, a cell whose flag is 0 sends only that flag bit.
- R6: A hit cell, or any cell when compression is off, sends its flag followed by all DW data bits, most significant bit first. Cell c's word is `cell_data[c*DW +: DW]`.
- R7: Cells are sent in ascending index order, beginning with cell 0.
- R8: `done` is 1 for exactly one cycle, the cycle right after the last stream bit, and `sdo_valid` is 0 in that cycle.
- R9: A start strobe that arrives while a readout is running is ignored. The stream in progress continues unchanged, and no second readout follows it.
- R10: The stream holds NCELL + DW·(number of hit cells) bits with compression on, and NCELL·(DW+1) bits with compression off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Readout start strobe |
| compress_en | input | 1 | 1 selects zero suppression |
| cell_data | input | NCELL*DW | Parallel data words, cell c at bits c*DW+DW-1 : c*DW |
| cell_hit | input | NCELL | Hit flag per cell |
| sdo | output | 1 | Serial data out |
| sdo_valid | output | 1 | High while `sdo` carries a stream bit |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The bench builds the block with NCELL=4 and DW=8. This keeps a full uncompressed stream at 36 bits, so every bit can be compared against a model the bench computes itself. Four cells are enough to place a hit first, in the middle and last. They also cover the all-empty stream, which is only four bits long, and the all-hit stream. The narrow word still leaves room for an upset start strobe, and for changed inputs, to land in the middle of a slot.

// File: rtl/zs_serial_readout.sv
module zs_serial_readout #(
  parameter int NCELL = 16,
  parameter int DW    = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                compress_en,
  input  logic [NCELL*DW-1:0] cell_data,
  input  logic [NCELL-1:0]    cell_hit,
  output logic                sdo,
  output logic                sdo_valid,
  output logic                done
);
  localparam int CW = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_CELL = CW'(NCELL - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DW);

  logic                busy, comp_q, done_q;
  logic [NCELL-1:0]    hit_q;
  logic [NCELL*DW-1:0] data_q;
  logic [CW-1:0]       ci;
  logic [BW-1:0]       bi;

  logic [DW-1:0] word;
  logic [BW-1:0] sel;
  logic          flag, slot_end;

  assign word     = data_q[ci*DW +: DW];
  assign flag     = hit_q[ci];
  assign sel      = (bi == '0) ? '0 : LAST_BIT - bi;
  assign slot_end = (bi == '0 && comp_q && !flag) || bi == LAST_BIT;

  assign sdo       = busy & ((bi == '0) ? flag : word[sel]);
  assign sdo_valid = busy;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      comp_q <= 1'b0;
      done_q <= 1'b0;
      hit_q  <= '0;
      data_q <= '0;
      ci     <= '0;
      bi     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          comp_q <= compress_en;
          hit_q  <= cell_hit;
          data_q <= cell_data;
          ci     <= '0;
          bi     <= '0;
        end
      end else if (slot_end) begin
        bi <= '0;
        if (ci == LAST_CELL) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ci <= ci + 1'b1;
        end
      end else begin
        bi <= bi + 1'b1;
      end
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_not_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && sdo_valid));
  p_done_follows_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sdo_valid));
  p_empty_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_valid && bi == '0 && comp_q && !sdo) |=> (bi == '0 || !sdo_valid));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_valid && start) |=> ($stable(comp_q) && $stable(hit_q) && $stable(data_q)));
  p_bit_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bi <= LAST_BIT);
endmodule

// File: tb/sim_zs_serial_readout.sv
module sim_zs_serial_readout;
  localparam int NC = 4;
  localparam int DW = 8;
  localparam int MAXB = NC * (DW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic compress_en = 1'b0;
  logic [NC*DW-1:0] cell_data = '0;
  logic [NC-1:0] cell_hit = '0;
  logic sdo, sdo_valid, done;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  zs_serial_readout #(.NCELL(NC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .compress_en(compress_en),
    .cell_data(cell_data), .cell_hit(cell_hit),
    .sdo(sdo), .sdo_valid(sdo_valid), .done(done));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input bit comp,
                          input logic [NC-1:0] hits,
                          input logic [NC*DW-1:0] data, input bit disturb);
    bit exp_b[MAXB];
    bit got_b[MAXB];
    int ne = 0;
    int ng = 0;
    int cyc = 0;
    bit gap = 0;
    bit first_ok = 0;
    int mism = -1;
    for (int c = 0; c < NC; c++) begin
      exp_b[ne++] = hits[c];
      if (!comp || hits[c])
        for (int b = DW - 1; b >= 0; b--) exp_b[ne++] = data[c*DW + b];
    end
    @(negedge clk);
    start = 1'b1; compress_en = comp; cell_hit = hits; cell_data = data;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) first_ok = sdo_valid;
      if (sdo_valid) begin
        if (ng < MAXB) got_b[ng] = sdo;
        ng++;
      end else if (!done) gap = 1;
      if (disturb && (cyc == 3 || cyc == 6)) begin
        start = 1'b1; compress_en = ~comp; cell_hit = ~hits; cell_data = ~data;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(first_ok, "R3", {tag, " first bit follows start"}, 0, 1);
    check(!gap, "R3", {tag, " valid without gaps"}, int'(gap), 0);
    check(ng == ne, "R10", {tag, " stream length"}, ng, ne);
    for (int i = 0; i < ne && i < ng; i++)
      if (mism < 0 && got_b[i] != exp_b[i]) mism = i;
    check(mism < 0, "R4/R5/R6/R7", {tag, " first mismatching bit index"}, mism, -1);
    check(done, "R8", {tag, " done seen"}, int'(done), 1);
    @(negedge clk);
    check(!done && !sdo_valid, "R8", {tag, " done lasts one cycle"},
          int'(done) + 2 * int'(sdo_valid), 0);
    if (disturb) begin
      repeat (4) @(negedge clk);
      check(!sdo_valid, "R9", {tag, " no second readout started"}, int'(sdo_valid), 0);
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!sdo && !sdo_valid && !done, "R1", "outputs in reset",
          int'(sdo) + int'(sdo_valid) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sdo && !sdo_valid && !done, "R1", "outputs after reset",
          int'(sdo) + int'(sdo_valid) + int'(done), 0);
  endtask

  // R7: a lone hit in cell 1 must appear after cell 0's flag only
  task automatic test_sparse;   run_case("R7 sparse compressed", 1'b1, 4'b0010, 32'hA53C_96E1, 1'b0); endtask
  // R5: all cells empty gives NC zero bits
  task automatic test_empty;    run_case("R5 empty compressed", 1'b1, 4'b0000, 32'hFFFF_FFFF, 1'b0); endtask
  // R4, R6: all cells hit
  task automatic test_full;     run_case("R6 full compressed", 1'b1, 4'b1111, 32'h8001_7E42, 1'b0); endtask
  // R6, R10: compression off sends every word
  task automatic test_plain;    run_case("R6 uncompressed", 1'b0, 4'b0101, 32'h1234_C3F0, 1'b0); endtask
  // R2, R9: restart and input changes mid-readout are ignored
  task automatic test_restart;  run_case("R2 R9 restart ignored", 1'b1, 4'b1000, 32'h5A00_0000, 1'b1); endtask

  initial begin
    test_reset();
    test_sparse();
    test_empty();
    test_full();
    test_plain();
    test_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule